// File: doc/BRIEF.md
# APB Watchdog Countdown Timer

This block is a down-counting watchdog timer reached through an APB slave port. Software programs a reload value, enables counting, and then has to acknowledge the timeout interrupt before the counter runs out a second time. The counter moves only on cycles where an external tick strobe is high and counting is enabled. Because the strobe comes from outside, the system can change its rate at any time without disturbing the count.

When the count reaches zero, the raw interrupt status is set and the counter stays at zero until the next tick, which reloads it. If the counter reaches zero again while the interrupt is still pending, and reset requests are enabled, a sticky reset-request output is raised. A write of any data to the clear register acknowledges the interrupt and restarts the count. A key-protected lock guards every register except the lock register itself.

Top module: `apb_wdog_timer`

## Requirements
- R1: After a synchronous active-low reset, the following values hold:
  - LOAD (offset 0x000) and VALUE (offset 0x004) read 0xFFFFFFFF.
  - CONTROL (offset 0x008) reads 0.
  - The raw status (offset 0x010, bit 0) and masked status (offset 0x014, bit 0) read 0.
  - LOCK (offset 0xC00) reads 0, meaning unlocked.
  - irq_o and rst_req_o are low.
- R2: While CONTROL bit 0 is 1, VALUE decreases by exactly one on each clock edge where tick_en is high. It holds its value when tick_en is low or CONTROL bit 0 is 0.
- R3: On the tick that brings VALUE to 0, the raw status becomes 1 and VALUE reads 0. On the next tick, VALUE reloads from LOAD while the raw status stays 1.
- R4: A write to LOAD updates both LOAD and VALUE with the written data, and both are visible from the following cycle.
- R5: A write of any data to INTCLR (offset 0x00C) clears the raw status and reloads VALUE from LOAD.
- R6: irq_o and the masked status equal the raw status AND CONTROL bit 0.
- R7: When CONTROL bit 1 is 1 and the counter reaches 0 while the raw status is already 1, rst_req_o goes high. It stays high until reset. With CONTROL bit 1 at 0 it never rises.
- R8: The lock works as follows:
  - Writing 0x1ACCE551 to LOCK unlocks; any other value locks.
  - LOCK bit 0 reads 1 when locked.
  - While locked, writes to LOAD, CONTROL and INTCLR have no effect.
- R9: Every tick strobe is counted once, whether ticks arrive on consecutive cycles or with idle cycles between them.
- R10: VALUE, raw status and masked status are read-only; writes to them change nothing.
- R11: A write to LOAD or INTCLR in the same cycle as a tick takes precedence. VALUE takes the reloaded value and that tick is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-enable strobe, one count per high cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, combinational from paddr |
| irq_o | output | 1 | Masked timeout interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The embedded assertions watch several properties on every cycle:
- the single-step decrement and the hold when idle;
- the reload from zero;
- the precedence of software reloads over ticks;
- the stickiness of the raw status and of the reset request;
- the rule that a reset request only rises while the interrupt is already pending;
- the blocking of reload writes while locked.

Only the bench scenarios can show end-to-end behaviour:
- long counts under changing tick spacing;
- the exact values read back at 500 and at zero;
- masking through CONTROL;
- the lock key handshake;
- that writes to read-only registers leave the count untouched.

// File: rtl/wdt_pkg.sv
// Package: shared constants and types for the APB watchdog timer.
// Assumes a 12-bit byte address space and 32-bit data for the unlock key.
package wdt_pkg;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_ADDR_W = 12;

    localparam logic [11:0] OFS_LOAD  = 12'h000;
    localparam logic [11:0] OFS_VALUE = 12'h004;
    localparam logic [11:0] OFS_CTRL  = 12'h008;
    localparam logic [11:0] OFS_CLR   = 12'h00C;
    localparam logic [11:0] OFS_RAW   = 12'h010;
    localparam logic [11:0] OFS_MSK   = 12'h014;
    localparam logic [11:0] OFS_LOCK  = 12'hC00;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    // Control register fields: bit 1 reset-request enable, bit 0 run/interrupt enable.
    typedef struct packed {
        logic rst_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
// Module: wdt_regs
// APB write decode and the software-owned registers (reload value, control,
// lock). Produces a one-cycle software reload request for the counter.
// Assumes writes complete in the APB access phase with no wait states.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] reload_o,
    output ctrl_t             ctrl_o,
    output logic              locked_o,
    output logic              sw_load_o,
    output logic [DATA_W-1:0] sw_val_o,
    output logic              clr_o
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [DATA_W-1:0] KEY      = DATA_W'(UNLOCK_KEY);

    logic wr_access;
    logic wr_open;
    logic hit_load, hit_ctrl, hit_clr, hit_lock;

    // Decode the access phase of a write and its target register.
    always_comb begin
        wr_access = psel & penable & pwrite;
        wr_open   = wr_access & ~locked_o;
        hit_load  = (paddr == ADDR_W'(OFS_LOAD));
        hit_ctrl  = (paddr == ADDR_W'(OFS_CTRL));
        hit_clr   = (paddr == ADDR_W'(OFS_CLR));
        hit_lock  = (paddr == ADDR_W'(OFS_LOCK));
    end

    // Software reload request: a LOAD write takes the new data, INTCLR the stored value.
    always_comb begin
        clr_o     = wr_open & hit_clr;
        sw_load_o = (wr_open & hit_load) | clr_o;
        sw_val_o  = (wr_open & hit_load) ? pwdata : reload_o;
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_o <= ALL_ONES;
        else if (wr_open && hit_load)
            reload_o <= pwdata;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_o <= '0;
        else if (wr_open && hit_ctrl)
            ctrl_o <= ctrl_t'(pwdata[1:0]);
    end

    // Lock state; writable regardless of lock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_o <= 1'b0;
        else if (wr_access && hit_lock)
            locked_o <= (pwdata != KEY);
    end

    // R8: while locked, a LOAD write must leave the reload value unchanged.
    assert_locked_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && wr_access && hit_load) |=> $stable(reload_o));

    // R8: the lock key always unlocks.
    assert_key_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_access && hit_lock && pwdata == KEY) |=> !locked_o);
endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// The down counter. Decrements per enabled tick, holds at zero for one tick,
// then reloads. A software reload has priority over a tick in the same cycle.
// Assumes tick_i is synchronous to clk and one cycle long per count.
module wdt_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic [DATA_W-1:0] reload_i,
    output logic [DATA_W-1:0] count_o,
    output logic              expire_o
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

    logic             step;
    logic [DATA_W-1:0] next_cnt;

    // Value the counter takes on an applied tick, and the expiry flag.
    always_comb begin
        step     = tick_i & run_i & ~load_i;
        next_cnt = (count_o == '0) ? reload_i : (count_o - ONE);
        expire_o = step & (next_cnt == '0);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_o <= ALL_ONES;
        else if (load_i)
            count_o <= load_val_i;
        else if (step)
            count_o <= next_cnt;
    end

    // R2: an applied tick on a nonzero count decrements by one.
    assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !load_i && count_o != '0) |=> count_o == $past(count_o) - ONE);

    // R2: with no tick or counting disabled and no software load, the count holds.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick_i && run_i) && !load_i) |=> $stable(count_o));

    // R3: a tick at zero reloads from the reload value.
    assert_zero_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !load_i && count_o == '0) |=> count_o == $past(reload_i));

    // R11: a software reload wins over a coincident tick.
    assert_sw_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && tick_i) |=> count_o == $past(load_val_i));
endmodule

// File: rtl/wdt_irq.sv
// Module: wdt_irq
// Raw interrupt status and the sticky reset request. Raw status sets on an
// expiry and clears on an acknowledge; a second expiry with the status still
// pending requests reset when enabled.
// Assumes expire_i and clear_i are never high together.
module wdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clear_i,
    input  logic rst_en_i,
    output logic raw_o,
    output logic rst_req_o
);
    // Raw interrupt status.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_o <= 1'b0;
        else if (clear_i)
            raw_o <= 1'b0;
        else if (expire_i)
            raw_o <= 1'b1;
    end

    // Sticky reset request; cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req_o <= 1'b0;
        else if (expire_i && raw_o && rst_en_i)
            rst_req_o <= 1'b1;
    end

    // R3: raw status stays set until acknowledged.
    assert_raw_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o && !clear_i) |=> raw_o);

    // R5: an acknowledge clears the raw status.
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !raw_o);

    // R7: the reset request never drops before reset.
    assert_rstreq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o);

    // R7: the reset request rises only while the interrupt was already pending.
    assert_rstreq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> ($past(raw_o) && $past(rst_en_i)));
endmodule

// File: rtl/apb_wdog_timer.sv
// Module: apb_wdog_timer (top)
// APB watchdog countdown timer: register block, counter, interrupt and
// reset-request logic, plus the read-data multiplexer.
// Assumes zero-wait-state APB; prdata is valid during the access phase.
module apb_wdog_timer
    import wdt_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq_o,
    output logic              rst_req_o
);
    logic [DATA_W-1:0] reload;
    ctrl_t             ctrl;
    logic              locked;
    logic              sw_load;
    logic [DATA_W-1:0] sw_val;
    logic              clr;
    logic [DATA_W-1:0] count;
    logic              expire;
    logic              raw;
    logic              masked;

    wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .reload_o  (reload),
        .ctrl_o    (ctrl),
        .locked_o  (locked),
        .sw_load_o (sw_load),
        .sw_val_o  (sw_val),
        .clr_o     (clr)
    );

    wdt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_en),
        .run_i      (ctrl.run),
        .load_i     (sw_load),
        .load_val_i (sw_val),
        .reload_i   (reload),
        .count_o    (count),
        .expire_o   (expire)
    );

    wdt_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire_i  (expire),
        .clear_i   (clr),
        .rst_en_i  (ctrl.rst_en),
        .raw_o     (raw),
        .rst_req_o (rst_req_o)
    );

    // Masked interrupt drives the output pin.
    always_comb begin
        masked = raw & ctrl.run;
        irq_o  = masked;
    end

    // Read-data multiplexer by address.
    always_comb begin
        prdata = '0;
        if (paddr == ADDR_W'(OFS_LOAD))
            prdata = reload;
        else if (paddr == ADDR_W'(OFS_VALUE))
            prdata = count;
        else if (paddr == ADDR_W'(OFS_CTRL))
            prdata = DATA_W'(ctrl);
        else if (paddr == ADDR_W'(OFS_RAW))
            prdata = DATA_W'(raw);
        else if (paddr == ADDR_W'(OFS_MSK))
            prdata = DATA_W'(masked);
        else if (paddr == ADDR_W'(OFS_LOCK))
            prdata = DATA_W'(locked);
    end

    // R1: the first cycle after reset shows no interrupt and no reset request.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        (!rst_n) |=> (!irq_o && !rst_req_o));
endmodule

// File: tb/apb_wdog_timer_tb.sv
// Scoreboard bench: driver tasks push expected items, a monitor compares them.
module apb_wdog_timer_tb_top;
    localparam logic [11:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTRL = 12'h008,
                            A_CLR = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014,
                            A_LOCK = 12'hC00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_o, rst_req_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];
    logic [31:0] mon_e, mon_a;
    string       mon_t;

    always #10 clk = ~clk;

    apb_wdog_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel),
        .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    // Monitor: pops expected and observed items and compares them.
    always @(negedge clk) begin
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_a = act_q.pop_front();
            mon_t = tag_q.pop_front();
            n_checks++;
            if (mon_a !== mon_e) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", mon_t, mon_a, mon_e);
            end
        end
    end

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1;
        #1 act_q.push_back(prdata);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic chk_pins(input logic i, input logic r, input string t);
        @(negedge clk);
        #1;
        exp_q.push_back({31'b0, i}); tag_q.push_back({t, " irq_o"}); act_q.push_back({31'b0, irq_o});
        exp_q.push_back({31'b0, r}); tag_q.push_back({t, " rst_req_o"}); act_q.push_back({31'b0, rst_req_o});
    endtask

    task automatic ticks(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_en = 1;
            @(negedge clk); tick_en = 0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic tick_burst(input int n);
        @(negedge clk); tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // Driver: scenarios per requirement.
    initial begin
        do_reset();
        // R1 reset state
        chk_rd(A_LOAD, 32'hFFFFFFFF, "R1 load");
        chk_rd(A_VAL, 32'hFFFFFFFF, "R1 value");
        chk_rd(A_CTRL, 0, "R1 ctrl");
        chk_rd(A_RAW, 0, "R1 raw");
        chk_rd(A_MSK, 0, "R1 masked");
        chk_rd(A_LOCK, 0, "R1 lock");
        chk_pins(0, 0, "R1");

        // R10 read-only registers
        apb_wr(A_VAL, 32'h55);
        chk_rd(A_VAL, 32'hFFFFFFFF, "R10 value write ignored");
        apb_wr(A_RAW, 1);
        apb_wr(A_MSK, 1);
        chk_rd(A_RAW, 0, "R10 raw write ignored");
        chk_pins(0, 0, "R10");

        // R2 hold while disabled
        ticks(3, 0);
        chk_rd(A_VAL, 32'hFFFFFFFF, "R2 disabled hold");

        // R4 load
        apb_wr(A_LOAD, 1000);
        chk_rd(A_VAL, 1000, "R4 value follows load");
        chk_rd(A_LOAD, 1000, "R4 load");

        // R2 counting
        apb_wr(A_CTRL, 1);
        ticks(500, 0);
        chk_rd(A_VAL, 500, "R2 value after 500 ticks");
        chk_rd(A_RAW, 0, "R2 raw still clear");
        repeat (10) @(negedge clk);
        chk_rd(A_VAL, 500, "R2 hold without tick");

        // R9 changing tick rate
        tick_burst(250);
        chk_rd(A_VAL, 250, "R9 burst ticks");
        ticks(249, 3);
        chk_rd(A_VAL, 1, "R9 spaced ticks");
        chk_rd(A_RAW, 0, "R9 raw before zero");

        // R3 expiry and reload
        ticks(1, 0);
        chk_rd(A_VAL, 0, "R3 value zero");
        chk_rd(A_RAW, 1, "R3 raw set");
        chk_rd(A_MSK, 1, "R6 masked set");
        chk_pins(1, 0, "R6");
        ticks(1, 0);
        chk_rd(A_VAL, 1000, "R3 reload after zero");
        chk_rd(A_RAW, 1, "R3 raw stays");

        // R5 acknowledge
        ticks(500, 0);
        chk_rd(A_VAL, 500, "R5 value before clear");
        apb_wr(A_CLR, 0);
        chk_rd(A_VAL, 1000, "R5 reload on clear");
        chk_rd(A_RAW, 0, "R5 raw cleared");
        chk_pins(0, 0, "R5");

        // R7 disabled reset request, R6 masking
        apb_wr(A_LOAD, 2);
        ticks(2, 0);
        chk_rd(A_RAW, 1, "R6 raw set");
        ticks(1, 0);
        ticks(2, 1);
        chk_pins(1, 0, "R7 no request when disabled");
        apb_wr(A_CTRL, 0);
        chk_rd(A_MSK, 0, "R6 masked off");
        chk_rd(A_RAW, 1, "R6 raw kept");
        chk_pins(0, 0, "R6 mask");
        apb_wr(A_CTRL, 1);
        apb_wr(A_CLR, 32'hDEAD);
        chk_rd(A_RAW, 0, "R5 clear any data");

        // R7 reset request
        apb_wr(A_CTRL, 3);
        ticks(2, 0);
        chk_pins(1, 0, "R7 first expiry");
        ticks(1, 0);
        ticks(2, 0);
        chk_pins(1, 1, "R7 second expiry");
        apb_wr(A_CLR, 0);
        chk_pins(0, 1, "R7 sticky");

        // R11 precedence
        apb_wr(A_LOAD, 100);
        ticks(10, 0);
        chk_rd(A_VAL, 90, "R11 setup");
        @(negedge clk); psel = 1; pwrite = 1; paddr = A_CLR; pwdata = 0; penable = 0;
        @(negedge clk); penable = 1; tick_en = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; tick_en = 0;
        chk_rd(A_VAL, 100, "R11 clear beats tick");
        ticks(1, 0);
        chk_rd(A_VAL, 99, "R11 tick after");

        // R8 lock
        apb_wr(A_LOCK, 32'h12345678);
        chk_rd(A_LOCK, 1, "R8 locked");
        apb_wr(A_LOAD, 7);
        chk_rd(A_LOAD, 100, "R8 load blocked");
        chk_rd(A_VAL, 99, "R8 value unchanged");
        apb_wr(A_CTRL, 0);
        chk_rd(A_CTRL, 3, "R8 ctrl blocked");
        apb_wr(A_CLR, 0);
        chk_rd(A_VAL, 99, "R8 clear blocked");
        apb_wr(A_LOCK, 32'h1ACCE551);
        chk_rd(A_LOCK, 0, "R8 unlocked");
        apb_wr(A_LOAD, 7);
        chk_rd(A_VAL, 7, "R8 load after unlock");

        // R1 reset clears request
        do_reset();
        chk_pins(0, 0, "R1 after reset");
        chk_rd(A_VAL, 32'hFFFFFFFF, "R1 value after reset");

        finish_run();
    end
endmodule